// File: doc/BRIEF.md
# Video Timing Reference Code Decoder

This block watches a 10-bit 4:2:2 component video word stream and picks out the four-word timing reference codes that mark the start and the end of active video on each line. A code begins with one all-ones word and two all-zeros words. The word after them is a status word. Its bits 8, 7 and 6 carry the field identity (F), field blanking (V) and line blanking (H). Its bits 5 down to 2 carry four protection bits. The decoder compares the seven protected bits with the eight legal code words. It repairs any single-bit error and reports a status word that lies two or more bits from every legal word.

The decoded field and blanking flags are registered, and they hold their values between codes. A good code raises a one-cycle start-of-active or end-of-active strobe, chosen by H. A status word that cannot be repaired raises a one-cycle error pulse and leaves the flags unchanged. The block also reports the ancillary data preamble (zeros, ones, ones) with its own pulse. It never treats the word that follows that preamble as a status word. Words presented with the valid input low are skipped, so the stream may contain gaps.

The parameter `PRE_CMP_BITS` sets how many of the most significant bits of each preamble word are compared. A value of 10 demands exact words. A value of 8 ignores the two low bits, to suit sources that only drive eight bits.

Top module: `trc_decoder`

## Requirements
- R1: During reset and on the first cycle after it, every output is 0: fld_o, vblank_o, hblank_o, sav_stb_o, eav_stb_o, code_err_o and anc_stb_o.
- R2: A valid word is a status word only when the three previous valid words were all-ones, all-zeros, all-zeros, in that order. Only the top PRE_CMP_BITS bits of those preamble words are compared, so with PRE_CMP_BITS=8 the preamble 0x3FE, 0x001, 0x003 is accepted, and with PRE_CMP_BITS=10 it is not. Any other preamble (for example 0x3FF, 0x000, 0x100) produces no strobe and no error.
- R3: In a status word, bit 8 is F, bit 7 is V and bit 6 is H. Bits 5 down to 2 are P3..P2..P1..P0, and a legal word has P3=V^H, P2=F^H, P1=F^V and P0=F^V^H. After an error-free status word, fld_o, vblank_o and hblank_o show F, V and H from the next cycle on. They then hold until the next accepted status word.
- R4: A status word whose bits 8..2 differ from a legal word in exactly one bit is decoded to that legal word's F, V and H, and code_err_o stays 0.
- R5: A status word whose bits 8..2 lie two or more bits from every legal word pulses code_err_o for one cycle, one cycle after the word. It raises no strobe and leaves fld_o, vblank_o and hblank_o unchanged.
- R6: A status word with bit 9 equal to 0 is handled as in R5, whatever its other bits are.
- R7: Bits 1 and 0 of the status word have no effect on the outputs.
- R8: An accepted status word with H=1 pulses eav_stb_o, and one with H=0 pulses sav_stb_o. The pulse is high for exactly one cycle, one cycle after the status word, and the two strobes are never high together.
- R9: Three consecutive valid words all-zeros, all-ones, all-ones (compared as in R2) pulse anc_stb_o for one cycle, one cycle after the third word. The next word is not decoded as a status word, so it raises no strobe and no error.
- R10: A cycle with din_vld low does not advance preamble detection and produces no strobe, error or ancillary pulse on the next cycle. A preamble and status word separated by such gaps are still decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_vld | input | 1 | Word on din is valid this cycle |
| din | input | WORD_W (10) | Incoming multiplexed video word |
| fld_o | output | 1 | Decoded field identity F, held |
| vblank_o | output | 1 | Decoded field blanking V, held |
| hblank_o | output | 1 | Decoded line blanking H, held |
| sav_stb_o | output | 1 | One-cycle start-of-active-video pulse |
| eav_stb_o | output | 1 | One-cycle end-of-active-video pulse |
| code_err_o | output | 1 | One-cycle uncorrectable status word pulse |
| anc_stb_o | output | 1 | One-cycle ancillary preamble pulse |

## Verification
The bench builds two copies side by side on one stimulus. One has PRE_CMP_BITS=8 and the other has the default of 10. Preambles with nonzero low bits are therefore accepted by one copy and rejected by the other, so both generate variants of the preamble compare are exercised. All eight F/V/H combinations are covered, along with single-bit repairs in the flag and protection fields, double and multi-bit errors, a cleared bit 9, and nonzero low bits in the status word. Both copies also see the ancillary preamble and preambles broken up by invalid cycles.

// File: rtl/trc_pkg.sv
package trc_pkg;

   localparam int TRC_WORD_W = 10;
   localparam int TRC_PROT_W = 7;   // F, V, H and four protection bits

   // legal protected field for a given {F,V,H}
   function automatic logic [TRC_PROT_W-1:0] trc_codeword(input logic [2:0] fvh);
      logic f, v, h;
      f = fvh[2];
      v = fvh[1];
      h = fvh[0];
      return {f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

endpackage

// File: rtl/trc_preamble_mon.sv
module trc_preamble_mon #(
   parameter int WORD_W   = 10,
   parameter int CMP_BITS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din_vld,
   input  logic [WORD_W-1:0] din,
   output logic              is_status,
   output logic              anc_seen
);

   if (CMP_BITS < 8 || CMP_BITS > WORD_W) begin : g_bad_cmp
      $error("trc_preamble_mon: CMP_BITS must lie in 8..WORD_W");
   end

   logic [CMP_BITS-1:0] key;

   if (CMP_BITS == WORD_W) begin : g_full_cmp
      assign key = din;
   end else begin : g_msb_cmp
      assign key = din[WORD_W-1 -: CMP_BITS];
   end

   logic cur_ones, cur_zero;
   assign cur_ones = &key;
   assign cur_zero = ~|key;

   // index 0 = previous valid word, 2 = three valid words back
   logic [2:0] hist_ones, hist_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_ones <= '0;
         hist_zero <= '0;
      end else if (din_vld) begin
         hist_ones <= {hist_ones[1:0], cur_ones};
         hist_zero <= {hist_zero[1:0], cur_zero};
      end
   end

   assign is_status = din_vld && hist_ones[2] && hist_zero[1] && hist_zero[0];
   assign anc_seen  = din_vld && hist_zero[1] && hist_ones[0] && cur_ones;

endmodule

// File: rtl/trc_fvh_corrector.sv
module trc_fvh_corrector
   import trc_pkg::*;
(
   input  logic [TRC_PROT_W-1:0] rx,
   output logic [2:0]            fvh,
   output logic                  ok
);

   logic [7:0] hit;

   for (genvar i = 0; i < 8; i++) begin : g_cw
      localparam logic [TRC_PROT_W-1:0] CW = trc_codeword(3'(i));
      assign hit[i] = ($countones(rx ^ CW) <= 1);
   end

   always_comb begin
      fvh = '0;
      for (int k = 0; k < 8; k++) begin
         if (hit[k]) fvh = fvh | 3'(k);
      end
   end

   assign ok = |hit;

   // R4: the code's distance leaves at most one legal word within one bit
   always_comb begin
      hit_onehot_chk: assert ($onehot0(hit));
   end

endmodule

// File: rtl/trc_decoder.sv
module trc_decoder
   import trc_pkg::*;
#(
   parameter int WORD_W       = 10,
   parameter int PRE_CMP_BITS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din_vld,
   input  logic [WORD_W-1:0] din,
   output logic              fld_o,
   output logic              vblank_o,
   output logic              hblank_o,
   output logic              sav_stb_o,
   output logic              eav_stb_o,
   output logic              code_err_o,
   output logic              anc_stb_o
);

   if (WORD_W != TRC_WORD_W) begin : g_bad_width
      $error("trc_decoder: WORD_W must equal 10");
   end

   logic is_status, anc_seen;

   trc_preamble_mon #(
      .WORD_W   (WORD_W),
      .CMP_BITS (PRE_CMP_BITS)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .din_vld   (din_vld),
      .din       (din),
      .is_status (is_status),
      .anc_seen  (anc_seen)
   );

   logic [2:0] corr_fvh;
   logic       corr_ok;

   trc_fvh_corrector u_corr (
      .rx  (din[WORD_W-2 -: TRC_PROT_W]),
      .fvh (corr_fvh),
      .ok  (corr_ok)
   );

   logic good;
   assign good = corr_ok && din[WORD_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {fld_o, vblank_o, hblank_o} <= '0;
         sav_stb_o  <= 1'b0;
         eav_stb_o  <= 1'b0;
         code_err_o <= 1'b0;
         anc_stb_o  <= 1'b0;
      end else begin
         sav_stb_o  <= is_status && good && !corr_fvh[0];
         eav_stb_o  <= is_status && good && corr_fvh[0];
         code_err_o <= is_status && !good;
         anc_stb_o  <= anc_seen;
         if (is_status && good) {fld_o, vblank_o, hblank_o} <= corr_fvh;
      end
   end

   // R8
   stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sav_stb_o && eav_stb_o));

   // R5
   err_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_err_o |-> !(sav_stb_o || eav_stb_o));

   // R10
   pulse_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sav_stb_o || eav_stb_o || code_err_o || anc_stb_o) |-> $past(din_vld));

   // R3
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({fld_o, vblank_o, hblank_o}) |-> (sav_stb_o || eav_stb_o));

   // R8
   eav_h_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eav_stb_o |-> hblank_o);

   // R8
   sav_h_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sav_stb_o |-> !hblank_o);

endmodule

// File: tb/trc_decoder_tb.sv
module trc_decoder_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       din_vld = 1'b0;
   logic [9:0] din = '0;

   logic [6:0] oa, ob;   // {fld, vb, hb, sav, eav, err, anc}

   always #2.5 clk = ~clk;

   trc_decoder #(.WORD_W(10), .PRE_CMP_BITS(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .din_vld(din_vld), .din(din),
      .fld_o(oa[6]), .vblank_o(oa[5]), .hblank_o(oa[4]),
      .sav_stb_o(oa[3]), .eav_stb_o(oa[2]), .code_err_o(oa[1]), .anc_stb_o(oa[0]));

   trc_decoder #(.WORD_W(10), .PRE_CMP_BITS(10)) u_full (
      .clk(clk), .rst_n(rst_n), .din_vld(din_vld), .din(din),
      .fld_o(ob[6]), .vblank_o(ob[5]), .hblank_o(ob[4]),
      .sav_stb_o(ob[3]), .eav_stb_o(ob[2]), .code_err_o(ob[1]), .anc_stb_o(ob[0]));

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   logic [2:0] fa = '0, fb = '0;   // expected held flags per instance

   // vector: [12:10] F,V,H  [9:3] flip mask on bits 8..2  [2:1] bits 1..0  [0] bit 9
   localparam int NV = 12;
   localparam logic [12:0] VEC [NV] = '{
      {3'b000, 7'h00, 2'd0, 1'b1},
      {3'b001, 7'h00, 2'd3, 1'b1},   // R7 low bits set
      {3'b010, 7'h40, 2'd0, 1'b1},   // R4 F flipped
      {3'b011, 7'h01, 2'd0, 1'b1},   // R4 P0 flipped
      {3'b100, 7'h08, 2'd0, 1'b1},   // R4 P3 flipped
      {3'b101, 7'h03, 2'd0, 1'b1},   // R5 two bits
      {3'b110, 7'h00, 2'd2, 1'b1},
      {3'b111, 7'h10, 2'd0, 1'b1},   // R4 H flipped
      {3'b111, 7'h00, 2'd0, 1'b0},   // R6 bit 9 clear
      {3'b001, 7'h7F, 2'd0, 1'b1},   // R5 all flipped
      {3'b100, 7'h22, 2'd1, 1'b1},   // R5 two bits
      {3'b010, 7'h04, 2'd0, 1'b1}    // R4 P2 flipped
   };

   function automatic logic [9:0] mk_xy(input logic [12:0] v);
      logic f, vv, h;
      logic [6:0] p;
      f  = v[12];
      vv = v[11];
      h  = v[10];
      p  = {f, vv, h, vv ^ h, f ^ h, f ^ vv, f ^ vv ^ h} ^ v[9:3];
      return {v[0], p, v[2:1]};
   endfunction

   task automatic chk1(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic chk_out(input string req, input string who, input logic [6:0] act,
                          input logic [2:0] ef, input logic es, input logic ee,
                          input logic er, input logic ean);
      n_chk++;
      if (act !== {ef, es, ee, er, ean}) begin
         n_fail++;
         $display("FAIL %s %s outputs: actual %b expected %b", req, who, act,
                  {ef, es, ee, er, ean});
      end
   endtask

   task automatic send(input logic [9:0] w);
      @(negedge clk);
      din     = w;
      din_vld = 1'b1;
   endtask

   task automatic gap(input logic [9:0] w);
      @(negedge clk);
      din     = w;
      din_vld = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk_out("R1", "reset a", oa, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_out("R1", "reset b", ob, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_out("R1", "post reset a", oa, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_out("R1", "post reset b", ob, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);

      // table walk: R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         logic err, h;
         err = !VEC[i][0] || ($countones(VEC[i][9:3]) >= 2);
         h   = VEC[i][10];
         send(10'h040);
         send(10'h3FF);
         send(10'h000);
         send(10'h000);
         send(mk_xy(VEC[i]));
         @(negedge clk);
         if (!err) begin
            fa = VEC[i][12:10];
            fb = VEC[i][12:10];
         end
         chk_out("R3/R4/R5/R6/R7/R8", "table a", oa, fa, !err && !h, !err && h, err, 1'b0);
         chk_out("R3/R4/R5/R6/R7/R8", "table b", ob, fb, !err && !h, !err && h, err, 1'b0);
         din = 10'h200;
      end
      @(negedge clk);
      chk_out("R8", "pulse ends a", oa, fa, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_out("R8", "pulse ends b", ob, fb, 1'b0, 1'b0, 1'b0, 1'b0);

      // R9 ancillary preamble, following word not decoded
      send(10'h000);
      send(10'h3FF);
      send(10'h3FF);
      @(negedge clk);
      chk1("R9", "anc pulse a", oa[0], 1'b1);
      chk1("R9", "anc pulse b", ob[0], 1'b1);
      din = 10'h274;
      @(negedge clk);
      chk_out("R9", "after anc a", oa, fa, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_out("R9", "after anc b", ob, fb, 1'b0, 1'b0, 1'b0, 1'b0);

      // R10 gaps inside a preamble
      send(10'h3FF);
      gap(10'h000);
      send(10'h000);
      gap(10'h3FF);
      send(10'h000);
      gap(10'h2D8);
      @(negedge clk);
      chk_out("R10", "gap word a", oa, fa, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_out("R10", "gap word b", ob, fb, 1'b0, 1'b0, 1'b0, 1'b0);
      din     = mk_xy({3'b110, 7'h20, 2'd0, 1'b1});
      din_vld = 1'b1;
      @(negedge clk);
      fa = 3'b110;
      fb = 3'b110;
      chk_out("R10", "gapped decode a", oa, fa, 1'b1, 1'b0, 1'b0, 1'b0);
      chk_out("R10", "gapped decode b", ob, fb, 1'b1, 1'b0, 1'b0, 1'b0);
      din = 10'h040;

      // R2 preamble with low bits set: only the 8-bit compare accepts it
      send(10'h3FE);
      send(10'h001);
      send(10'h003);
      send(mk_xy({3'b011, 7'h00, 2'd0, 1'b1}));
      @(negedge clk);
      fa = 3'b011;
      chk_out("R2", "msb preamble a", oa, fa, 1'b0, 1'b1, 1'b0, 1'b0);
      chk_out("R2", "msb preamble b", ob, fb, 1'b0, 1'b0, 1'b0, 1'b0);
      din = 10'h040;

      // R2 broken preamble
      send(10'h3FF);
      send(10'h000);
      send(10'h100);
      send(mk_xy({3'b000, 7'h00, 2'd0, 1'b1}));
      @(negedge clk);
      chk_out("R2", "broken preamble a", oa, fa, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_out("R2", "broken preamble b", ob, fb, 1'b0, 1'b0, 1'b0, 1'b0);
      din_vld = 1'b0;

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule